// File: doc/BRIEF.md
# Pin change interrupt unit

This unit watches every line of an 8-bit or 16-bit general-purpose port and raises an interrupt when an enabled line changes. Each line runs in one of two compare modes. In previous-value mode, the line triggers on any change of its synchronized level from the prior cycle. In reference mode, the line triggers for as long as its level differs from a programmed reference bit. Software uses a small register interface to set the enables, the reference bits and the mode bits, and to read the flags, a frozen port snapshot and the live port.

The first qualifying event seen while no interrupt is pending freezes a snapshot of the whole synchronized port. The snapshot stays frozen until software reads the snapshot register or the live port register. Either read clears every flag. Events that arrive while an interrupt is pending add flags but leave the snapshot alone. In reference mode, a line that still differs after a clearing read sets its flag again, so the interrupt behaves as a level.

Top module: `pin_change_irq`

## Requirements
- R1: After reset `irq_no` is high, and the enable, reference, mode, flag and snapshot registers all read zero.
- R2: Address 0 is the enable register, address 1 the reference register and address 2 the mode register; all three are read/write. Address 3 (flags), address 4 (snapshot) and address 5 (live synchronized port) are read-only. Reads of any other address return zero.
- R3: With its mode bit at 0 and its enable bit at 1, a pin sets its flag on any change of its level. The flag is visible at the third rising edge after the input changes.
- R4: With its mode bit at 1 and its enable bit at 1, a pin sets its flag while its synchronized level differs from its reference bit.
- R5: A pin whose enable bit is 0 never sets a flag and never causes a snapshot.
- R6: `irq_no` is low exactly while at least one flag is set.
- R7: A qualifying event that arrives while no flag is set loads the snapshot with the whole synchronized port.
- R8: Events that arrive while a flag is already set add their flags but leave the snapshot unchanged.
- R9: A read of address 4 or address 5 clears all flags. A read of address 3 does not clear them.
- R10: In reference mode, a pin that still differs from its reference when a clearing read happens has its flag set again in the next cycle, and the snapshot is reloaded.
- R11: Writes to addresses 3, 4 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | N | Port pin levels, asynchronous to the clock |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; reading a clearing address clears the flags |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | N | Write data |
| reg_rdata_o | output | N | Read data, combinational from the address |
| irq_no | output | 1 | Interrupt output, active low |

## Verification
The hardest case to reach is a second event that arrives while an interrupt is already pending, because that is where the snapshot must stay frozen even though the flags grow. The stimulus moves one enabled pin, waits until the interrupt is visible, then moves a second enabled pin before any clearing read. It then checks that the flag register holds both bits while the snapshot still shows the port as it was at the first event. The level-style re-trigger in reference mode is reached by holding a pin away from its reference across a clearing snapshot read. The bench then confirms that the interrupt never releases and that the snapshot was reloaded.

// File: rtl/pin_change_pkg.sv
package pin_change_pkg;
  localparam int unsigned REG_IEN  = 0;
  localparam int unsigned REG_REF  = 1;
  localparam int unsigned REG_MODE = 2;
  localparam int unsigned REG_FLAG = 3;
  localparam int unsigned REG_SNAP = 4;
  localparam int unsigned REG_PORT = 5;
endpackage

// File: rtl/pin_change_sync.sv
module pin_change_sync #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_s_o
);
  for (genvar g = 0; g < N; g++) begin : g_sync
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
      end
    end
    assign pin_s_o[g] = s2_q;
  end
endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_s_i,
  input  logic [N-1:0] ien_i,
  input  logic [N-1:0] ref_i,
  input  logic [N-1:0] mode_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_s_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic diff;
    // mode 1: compare to reference, mode 0: compare to last cycle
    assign diff     = mode_i[g] ? (pin_s_i[g] ^ ref_i[g]) : (pin_s_i[g] ^ prev_q[g]);
    assign evt_o[g] = ien_i[g] & diff;
  end
endmodule

// File: rtl/pin_change_regs.sv
module pin_change_regs
  import pin_change_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N-1:0]      wdata_i,
  input  logic [N-1:0]      pin_s_i,
  input  logic [N-1:0]      evt_i,
  output logic [N-1:0]      rdata_o,
  output logic [N-1:0]      ien_o,
  output logic [N-1:0]      ref_o,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      flag_o,
  output logic [N-1:0]      snap_o,
  output logic              clr_o
);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(REG_IEN);
  localparam logic [ADDR_W-1:0] A_REF  = ADDR_W'(REG_REF);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(REG_MODE);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(REG_FLAG);
  localparam logic [ADDR_W-1:0] A_SNAP = ADDR_W'(REG_SNAP);
  localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(REG_PORT);

  logic [N-1:0] ien_q, ref_q, mode_q, flag_q, snap_q, flag_d;
  logic         pending, clr, cap;

  assign pending = |flag_q;
  assign clr     = re_i & ((addr_i == A_SNAP) | (addr_i == A_PORT));
  // events in the clearing cycle survive and may reload the snapshot
  assign flag_d  = (clr ? '0 : flag_q) | evt_i;
  assign cap     = (|evt_i) & (clr | ~pending);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      ref_q  <= '0;
      mode_q <= '0;
      flag_q <= '0;
      snap_q <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_IEN:   ien_q  <= wdata_i;
          A_REF:   ref_q  <= wdata_i;
          A_MODE:  mode_q <= wdata_i;
          default: ;
        endcase
      end
      flag_q <= flag_d;
      if (cap) snap_q <= pin_s_i;
    end
  end

  always_comb begin
    case (addr_i)
      A_IEN:   rdata_o = ien_q;
      A_REF:   rdata_o = ref_q;
      A_MODE:  rdata_o = mode_q;
      A_FLAG:  rdata_o = flag_q;
      A_SNAP:  rdata_o = snap_q;
      A_PORT:  rdata_o = pin_s_i;
      default: rdata_o = '0;
    endcase
  end

  assign ien_o  = ien_q;
  assign ref_o  = ref_q;
  assign mode_o = mode_q;
  assign flag_o = flag_q;
  assign snap_o = snap_q;
  assign clr_o  = clr;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int unsigned N      = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      pin_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [N-1:0]      reg_wdata_i,
  output logic [N-1:0]      reg_rdata_o,
  output logic              irq_no
);
  logic [N-1:0] pin_s, evt, ien_q, ref_q, mode_q, flag_q, snap_q;
  logic         clr;

  pin_change_sync #(.N(N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .pin_s_o (pin_s)
  );

  pin_change_detect #(.N(N)) u_detect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_s_i (pin_s),
    .ien_i   (ien_q),
    .ref_i   (ref_q),
    .mode_i  (mode_q),
    .evt_o   (evt)
  );

  pin_change_regs #(.N(N), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .pin_s_i (pin_s),
    .evt_i   (evt),
    .rdata_o (reg_rdata_o),
    .ien_o   (ien_q),
    .ref_o   (ref_q),
    .mode_o  (mode_q),
    .flag_o  (flag_q),
    .snap_o  (snap_q),
    .clr_o   (clr)
  );

  assign irq_no = ~(|flag_q);
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] evt,
  input logic [N-1:0] flag_q,
  input logic [N-1:0] ien_q,
  input logic [N-1:0] snap_q,
  input logic         clr,
  input logic         irq_no
);
  // R5
  disabled_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(ien_q)) == '0));

  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(|evt));

  // R8
  snap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|flag_q) && !clr) |=> $stable(snap_q));

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && (evt == '0)) |=> (flag_q == '0));

  // R10
  level_retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && (|evt)) |=> !irq_no);
endmodule

bind pin_change_irq pin_change_irq_chk #(.N(N)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .evt    (evt),
  .flag_q (flag_q),
  .ien_q  (ien_q),
  .snap_q (snap_q),
  .clr    (clr),
  .irq_no (irq_no)
);

// File: tb/pin_change_irq_bench.sv
`timescale 1ns/1ps
module pin_change_irq_bench;
  localparam int N = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [N-1:0] exp; string req; } item_t;
  item_t sb_q[$];
  event  sample_ev;

  always #4 clk = ~clk;

  pin_change_irq #(.N(N), .ADDR_W(AW)) u_pin_change_irq (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_no(irq_n)
  );

  // monitor: pops expected read data and compares
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s read: actual %h expected %h", it.req, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input int a, input logic [N-1:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [N-1:0] e, input string req);
    @(negedge clk);
    re = 1'b1; addr = AW'(a);
    sb_q.push_back('{e, req});
    #2 -> sample_ev;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string req);
    @(negedge clk);
    checks++;
    if (irq_n !== e) begin
      fails++;
      $display("FAIL %s irq_no: actual %b expected %b", req, irq_n, e);
    end
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b1, "R1");
    rd(0, 8'h00, "R1"); rd(1, 8'h00, "R1"); rd(2, 8'h00, "R1");
    rd(3, 8'h00, "R1"); rd(4, 8'h00, "R1");
    // R2 register access
    wr(1, 8'hA5); rd(1, 8'hA5, "R2");
    wr(2, 8'h3C); rd(2, 8'h3C, "R2");
    rd(7, 8'h00, "R2");
    wr(1, 8'h00); wr(2, 8'h00);
    // R11 writes to read-only addresses
    wr(3, 8'hFF); wr(4, 8'hFF);
    chk_irq(1'b1, "R11"); rd(3, 8'h00, "R11"); rd(4, 8'h00, "R11");
    // R3 previous-value mode, timing at third edge
    wr(0, 8'h01);
    @(negedge clk); pins = 8'h01;
    @(negedge clk); @(negedge clk);
    checks++;
    if (irq_n !== 1'b1) begin fails++; $display("FAIL R3 early irq: actual %b expected 1", irq_n); end
    @(negedge clk);
    checks++;
    if (irq_n !== 1'b0) begin fails++; $display("FAIL R3 irq at third edge: actual %b expected 0", irq_n); end
    rd(3, 8'h01, "R3");
    // R9 flag read does not clear
    chk_irq(1'b0, "R9");
    // R7 snapshot
    rd(4, 8'h01, "R7");
    chk_irq(1'b1, "R9"); rd(3, 8'h00, "R9");
    // R5 disabled pin
    set_pins(8'h03);
    chk_irq(1'b1, "R5"); rd(3, 8'h00, "R5"); rd(4, 8'h01, "R5");
    // R8 snapshot frozen while pending
    wr(0, 8'h03);
    set_pins(8'h02);
    chk_irq(1'b0, "R6");
    set_pins(8'h00);
    rd(3, 8'h03, "R8"); rd(4, 8'h02, "R8");
    chk_irq(1'b1, "R6"); rd(3, 8'h00, "R9");
    // R9 port read clears
    set_pins(8'h01);
    rd(5, 8'h01, "R9");
    chk_irq(1'b1, "R9"); rd(3, 8'h00, "R9");
    // R4 reference mode
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h04); wr(0, 8'h04);
    chk_irq(1'b1, "R4");
    set_pins(8'h05);
    rd(3, 8'h04, "R4");
    // R10 level retrigger
    rd(4, 8'h05, "R10");
    chk_irq(1'b0, "R10"); rd(3, 8'h04, "R10");
    set_pins(8'h01);
    rd(4, 8'h05, "R10");
    chk_irq(1'b1, "R4"); rd(3, 8'h00, "R4");
    // R4 reference at one, pin low
    wr(1, 8'h04);
    repeat (2) @(negedge clk);
    chk_irq(1'b0, "R4"); rd(3, 8'h04, "R4");
    rd(4, 8'h01, "R10");
    wr(1, 8'h00); rd(5, 8'h01, "R9");
    chk_irq(1'b1, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule